// File: doc/BRIEF.md
# Load/Store Multiple Register Sequencer

This block turns one compact "save or restore a group of registers" command into a series of single memory beats. A command carries a 5-bit list field, a base address, a direction select (load or store) and a size select (32-bit word or 64-bit doubleword). The low four bits of the list field give a count of registers taken from a fixed, non-contiguous table. The top bit asks for one extra transfer of the return-address register. The sequencer walks through the listed registers in order and issues one memory request per register, advancing the address by the access size.

On a load, each returned value is written into the register file. Word values are sign-extended to 64 bits first. On a store, the sequencer reads each register through a combinational read port and places its value on the memory write data. A one-cycle completion pulse ends every command, including a command that lists nothing. A new command is taken only while the sequencer is idle.

Top module: `lsm_seq`

## Requirements
- R1: A count in the range 1 to 9 (list bits [3:0]) transfers exactly that many registers, in this order: 16, 17, 18, 19, 20, 21, 22, 23, 30.
- R2: A count of 0, or of 10 to 15, transfers no table registers.
- R3: When list bit 4 is 1, register 31 is transferred once, after all table transfers.
- R4: Beat k goes to base + 4·k in word mode (size select 0) and to base + 8·k in doubleword mode (size select 1).
- R5: On a load (store select 0), a word-mode value is written as bits [31:0] of the returned data, sign-extended from bit 31. A doubleword value is written unchanged. Exactly one register-file write happens per accepted beat.
- R6: The register-31 beat uses the address that follows the last table beat, or the base address when the table part is skipped.
- R7: On a store, the write data is the register value in doubleword mode and the register's low 32 bits with the upper half zero in word mode. The register file is not written.
- R8: Completion is a pulse one cycle wide. It comes one cycle after the last beat is acknowledged, or one cycle after acceptance when nothing is listed, in which case no memory request is made.
- R9: A command is accepted only when the ready output is 1 (idle). A command offered while the block is busy has no effect on the running sequence.
- R10: A memory request stays asserted with a stable address until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block is idle and takes a command |
| cmd_list | input | 5 | [3:0] table count, [4] add register 31 |
| cmd_base | input | AW | Base byte address |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_dword | input | 1 | 1 = doubleword, 0 = word |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | Beat is a write |
| mem_dword | output | 1 | Beat size is a doubleword |
| mem_addr | output | AW | Beat byte address |
| mem_wdata | output | XLEN | Store data |
| mem_ack | input | 1 | Beat accepted; load data valid |
| mem_rdata | input | XLEN | Load data |
| rf_raddr | output | 5 | Register-file read index |
| rf_rdata | input | XLEN | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | XLEN | Register-file write data |

## Verification
The hardest situation to reach from the ports is a new command that arrives while a sequence is still running. It must be ignored, even though it lists a different count and flips direction. The stimulus sweeps all 32 list values in every direction and size. On alternate commands it holds a conflicting command valid for the whole busy period. Memory acknowledge latency varies from zero to two cycles per beat, so every beat is seen both held and accepted at once. Loaded values alternate bit 31 so that sign extension is exercised both ways.

// File: rtl/lsm_pkg.sv
// Shared constants and types for the load/store multiple sequencer.
// Assumes the fixed register table is a run of consecutive registers
// followed by a single tail register.
package lsm_pkg;
    localparam int LIST_W      = 5;
    localparam int CNT_W       = 4;
    localparam int REG_W       = 5;
    localparam int RUN_FIRST   = 16;
    localparam int RUN_LEN     = 8;
    localparam int TAIL_REG    = 30;
    localparam int TBL_LEN     = RUN_LEN + 1;
    localparam int RA_REG      = 31;
    localparam int WORD_BYTES  = 4;
    localparam int DWORD_BYTES = 8;
    localparam int BEAT_W      = $clog2(TBL_LEN + 2);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } lsm_state_t;
endpackage

// File: rtl/lsm_list_decode.sv
// Decodes the list field of an incoming command into a table count and
// a total beat count. Assumes the field is only meaningful when a
// command is accepted; purely combinational.
module lsm_list_decode
    import lsm_pkg::*;
(
    input  logic [LIST_W-1:0] list_i,
    output logic [BEAT_W-1:0] tbl_n_o,
    output logic [BEAT_W-1:0] total_o
);
    logic [CNT_W-1:0] cnt;
    logic             cnt_ok;

    // Out-of-range counts collapse to zero table beats.
    always_comb begin
        cnt     = list_i[CNT_W-1:0];
        cnt_ok  = (cnt != '0) && (int'(cnt) <= TBL_LEN);
        tbl_n_o = cnt_ok ? BEAT_W'(cnt) : '0;
        total_o = tbl_n_o + BEAT_W'(list_i[LIST_W-1]);
    end
endmodule

// File: rtl/lsm_reg_sel.sv
// Maps a beat index to an architectural register number: indices below
// the table count come from the fixed table, the next one is the
// return-address register. Assumes idx_i < table count + 1.
module lsm_reg_sel
    import lsm_pkg::*;
(
    input  logic [BEAT_W-1:0] idx_i,
    input  logic [BEAT_W-1:0] tbl_n_i,
    output logic [REG_W-1:0]  reg_o
);
    logic [REG_W-1:0] tbl [TBL_LEN];

    // Table entries: a consecutive run, then one tail register.
    for (genvar g = 0; g < TBL_LEN; g++) begin : g_tbl
        if (g < RUN_LEN) begin : g_run
            assign tbl[g] = REG_W'(RUN_FIRST + g);
        end else begin : g_tail
            assign tbl[g] = REG_W'(TAIL_REG);
        end
    end

    // Select the table entry or fall through to the return-address register.
    always_comb begin
        reg_o = REG_W'(RA_REG);
        if (idx_i < tbl_n_i) begin
            for (int i = 0; i < TBL_LEN; i++) begin
                if (idx_i == BEAT_W'(i)) reg_o = tbl[i];
            end
        end
    end
endmodule

// File: rtl/lsm_ctrl.sv
// Sequencing FSM: latches a command while idle, steps one beat per
// memory acknowledge, advances the address by the access size and
// pulses done for one cycle. Assumes mem_ack_i is only meaningful
// while a request is up.
module lsm_ctrl
    import lsm_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [AW-1:0]     cmd_base_i,
    input  logic              cmd_store_i,
    input  logic              cmd_dword_i,
    input  logic [BEAT_W-1:0] tbl_n_i,
    input  logic [BEAT_W-1:0] total_i,
    input  logic              mem_ack_i,
    output logic              cmd_ready_o,
    output logic              req_o,
    output logic              fire_o,
    output logic              last_o,
    output logic [BEAT_W-1:0] idx_o,
    output logic [BEAT_W-1:0] tbl_n_o,
    output logic [AW-1:0]     addr_o,
    output logic              store_o,
    output logic              dword_o,
    output logic              done_o
);
    lsm_state_t        state;
    logic [BEAT_W-1:0] idx, total_q, tbl_n_q;
    logic [AW-1:0]     addr;
    logic              store_q, dword_q;
    logic [AW-1:0]     stride;

    // Beat status derived from the current state.
    always_comb begin
        stride      = dword_q ? AW'(DWORD_BYTES) : AW'(WORD_BYTES);
        cmd_ready_o = (state == ST_IDLE);
        req_o       = (state == ST_XFER);
        fire_o      = req_o && mem_ack_i;
        last_o      = (idx == total_q - BEAT_W'(1));
        done_o      = (state == ST_DONE);
    end

    // State, beat index, address and latched command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            total_q <= '0;
            tbl_n_q <= '0;
            addr    <= '0;
            store_q <= 1'b0;
            dword_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (cmd_valid_i) begin
                    idx     <= '0;
                    total_q <= total_i;
                    tbl_n_q <= tbl_n_i;
                    addr    <= cmd_base_i;
                    store_q <= cmd_store_i;
                    dword_q <= cmd_dword_i;
                    state   <= (total_i == '0) ? ST_DONE : ST_XFER;
                end
                ST_XFER: if (mem_ack_i) begin
                    idx  <= idx + BEAT_W'(1);
                    addr <= addr + stride;
                    if (last_o) state <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign idx_o   = idx;
    assign tbl_n_o = tbl_n_q;
    assign addr_o  = addr;
    assign store_o = store_q;
    assign dword_o = dword_q;

    // R8: completion lasts exactly one cycle.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10: a pending request holds with the same address.
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !mem_ack_i) |=> (req_o && $stable(addr_o)));
    // R4: an acknowledged non-final beat moves the address by the size.
    a_r4_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && !last_o) |=> (req_o && addr_o == $past(addr_o) +
            ($past(dword_o) ? AW'(DWORD_BYTES) : AW'(WORD_BYTES))));
    // R9: no command is taken while a request is outstanding.
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> !cmd_ready_o);
endmodule

// File: rtl/lsm_seq.sv
// Load/store multiple sequencer top: decodes the list field, selects the
// register for each beat and forms register-file and memory data.
// Assumes a combinational register-file read port and one memory beat
// in flight at a time.
module lsm_seq
    import lsm_pkg::*;
#(
    parameter int AW   = 32,
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [LIST_W-1:0] cmd_list,
    input  logic [AW-1:0]     cmd_base,
    input  logic              cmd_store,
    input  logic              cmd_dword,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_dword,
    output logic [AW-1:0]     mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic              mem_ack,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic [REG_W-1:0]  rf_raddr,
    input  logic [XLEN-1:0]   rf_rdata,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr,
    output logic [XLEN-1:0]   rf_wdata
);
    localparam int HALF = XLEN / 2;

    logic [BEAT_W-1:0] dec_tbl_n, dec_total, idx, tbl_n_q;
    logic              fire, last_beat, store_q, dword_q;
    logic [REG_W-1:0]  cur_reg;

    lsm_list_decode u_dec (
        .list_i  (cmd_list),
        .tbl_n_o (dec_tbl_n),
        .total_o (dec_total)
    );

    lsm_ctrl #(.AW(AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid),
        .cmd_base_i  (cmd_base),
        .cmd_store_i (cmd_store),
        .cmd_dword_i (cmd_dword),
        .tbl_n_i     (dec_tbl_n),
        .total_i     (dec_total),
        .mem_ack_i   (mem_ack),
        .cmd_ready_o (cmd_ready),
        .req_o       (mem_req),
        .fire_o      (fire),
        .last_o      (last_beat),
        .idx_o       (idx),
        .tbl_n_o     (tbl_n_q),
        .addr_o      (mem_addr),
        .store_o     (store_q),
        .dword_o     (dword_q),
        .done_o      (done)
    );

    lsm_reg_sel u_sel (
        .idx_i   (idx),
        .tbl_n_i (tbl_n_q),
        .reg_o   (cur_reg)
    );

    // Beat attributes and data formatting in both directions.
    always_comb begin
        mem_we    = mem_req && store_q;
        mem_dword = dword_q;
        rf_raddr  = cur_reg;
        rf_waddr  = cur_reg;
        rf_we     = fire && !store_q;
        mem_wdata = dword_q ? rf_rdata : {{HALF{1'b0}}, rf_rdata[HALF-1:0]};
        rf_wdata  = dword_q ? mem_rdata
                            : {{HALF{mem_rdata[HALF-1]}}, mem_rdata[HALF-1:0]};
    end

    // R3: a write to the return-address register is always the final beat.
    a_r3_ra_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_waddr == REG_W'(RA_REG)) |-> last_beat);
    // R7: stores never write the register file.
    a_r7_store_no_rf: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !rf_we);
endmodule

// File: tb/lsm_seq_tb.sv
module lsm_seq_tb;
    localparam int AW = 32;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic            cmd_ready;
    logic [4:0]      cmd_list = '0;
    logic [AW-1:0]   cmd_base = '0;
    logic            cmd_store = 1'b0;
    logic            cmd_dword = 1'b0;
    logic            done;
    logic            mem_req, mem_we, mem_dword;
    logic [AW-1:0]   mem_addr;
    logic [XLEN-1:0] mem_wdata;
    logic            mem_ack = 1'b0;
    logic [XLEN-1:0] mem_rdata = '0;
    logic [4:0]      rf_raddr;
    logic [XLEN-1:0] rf_rdata;
    logic            rf_we;
    logic [4:0]      rf_waddr;
    logic [XLEN-1:0] rf_wdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    function automatic logic [XLEN-1:0] rf_val(input logic [4:0] r);
        return {32'hC300_0000 ^ ({27'd0, r} * 32'h0101_0101),
                32'h1234_0000 + {27'd0, r} * 32'd7};
    endfunction

    function automatic logic [XLEN-1:0] mem_val(input logic [AW-1:0] a);
        return {a ^ 32'h5A5A_0000,
                (a * 32'h0001_0003) ^ (a[3] ? 32'h8000_0000 : 32'h0)};
    endfunction

    assign rf_rdata = rf_val(rf_raddr);

    lsm_seq #(.AW(AW), .XLEN(XLEN)) u_dut (
        .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_list, .cmd_base,
        .cmd_store, .cmd_dword, .done, .mem_req, .mem_we, .mem_dword,
        .mem_addr, .mem_wdata, .mem_ack, .mem_rdata, .rf_raddr, .rf_rdata,
        .rf_we, .rf_waddr, .rf_wdata
    );

    task automatic chk(input logic ok, input string req,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [4:0] lst, input logic st,
                           input logic dw, input logic [AW-1:0] base,
                           input int k);
        int tn;
        int n;
        logic [4:0] regs [10];
        logic [AW-1:0] stride;
        logic [AW-1:0] ea;
        logic [XLEN-1:0] rd, exp_w;
        tn = (lst[3:0] >= 4'd1 && lst[3:0] <= 4'd9) ? int'(lst[3:0]) : 0;
        n = tn + int'(lst[4]);
        for (int i = 0; i < tn; i++) regs[i] = (i < 8) ? 5'(16 + i) : 5'd30;
        if (lst[4]) regs[tn] = 5'd31;
        stride = dw ? 32'd8 : 32'd4;

        @(negedge clk);
        chk(cmd_ready == 1'b1, "R9 idle ready", {63'd0, cmd_ready}, 64'd1);
        cmd_valid = 1'b1; cmd_list = lst; cmd_base = base;
        cmd_store = st; cmd_dword = dw;
        @(negedge clk);
        if (n == 0 || (k % 2) == 0) begin
            cmd_valid = 1'b0;
        end else begin
            cmd_list = ~lst; cmd_base = base ^ 32'h0000_FFF0;
            cmd_store = ~st; cmd_dword = ~dw;
        end
        if (n == 0) begin
            chk(done == 1'b1, "R2 R8 empty list done", {63'd0, done}, 64'd1);
            chk(mem_req == 1'b0, "R8 empty list no request", {63'd0, mem_req}, 64'd0);
        end else begin
            for (int b = 0; b < n; b++) begin
                ea = base + stride * AW'(b);
                for (int w = 0; w < (b + k) % 3; w++) begin
                    chk(mem_req && !cmd_ready, "R10 request held",
                        {63'd0, mem_req}, 64'd1);
                    chk(mem_addr == ea, "R10 address stable",
                        {32'd0, mem_addr}, {32'd0, ea});
                    @(negedge clk);
                    mem_ack = 1'b0;
                end
                chk(mem_req == 1'b1, "R1 beat requested", {63'd0, mem_req}, 64'd1);
                chk(mem_addr == ea, (lst[4] && b == tn) ? "R6 ra address" : "R4 beat address",
                    {32'd0, mem_addr}, {32'd0, ea});
                chk(mem_we == st && mem_dword == dw, "R7 beat kind",
                    {62'd0, mem_we, mem_dword}, {62'd0, st, dw});
                chk(rf_raddr == regs[b], (b == tn) ? "R3 ra register" : "R1 table register",
                    {59'd0, rf_raddr}, {59'd0, regs[b]});
                if (st) begin
                    exp_w = dw ? rf_val(regs[b]) : {32'd0, rf_val(regs[b])[31:0]};
                    chk(mem_wdata == exp_w, "R7 store data", mem_wdata, exp_w);
                end
                mem_ack = 1'b1;
                rd = mem_val(ea);
                mem_rdata = rd;
                #1;
                if (st) begin
                    chk(rf_we == 1'b0, "R7 no rf write", {63'd0, rf_we}, 64'd0);
                end else begin
                    exp_w = dw ? rd : {{32{rd[31]}}, rd[31:0]};
                    chk(rf_we == 1'b1 && rf_waddr == regs[b], "R5 rf write index",
                        {58'd0, rf_we, rf_waddr}, {58'd0, 1'b1, regs[b]});
                    chk(rf_wdata == exp_w, "R5 load data", rf_wdata, exp_w);
                end
                @(negedge clk);
                mem_ack = 1'b0;
            end
            chk(done == 1'b1, "R8 done after last beat", {63'd0, done}, 64'd1);
            chk(mem_req == 1'b0, "R8 no request at done", {63'd0, mem_req}, 64'd0);
            cmd_valid = 1'b0;
        end
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", {63'd0, done}, 64'd0);
        chk(mem_req == 1'b0 && cmd_ready == 1'b1, "R9 back to idle",
            {62'd0, mem_req, cmd_ready}, 64'd1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b1 && mem_req == 1'b0 && done == 1'b0 && rf_we == 1'b0,
            "R9 reset state", {60'd0, cmd_ready, mem_req, done, rf_we}, 64'd8);
        k = 0;
        for (int l = 0; l < 32; l++) begin
            for (int s = 0; s < 2; s++) begin
                for (int d = 0; d < 2; d++) begin
                    run_cmd(5'(l), s[0], d[0], 32'h0000_1000 + AW'(k) * 32'h48, k);
                    k++;
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule